// File: doc/BRIEF.md
# Main Clock Loss Detector Register

This block watches a main clock from the side of an always-running on-chip reference oscillator. A toggle flop in the main domain is carried into the reference domain through a synchronizer. If no toggle arrives for a configurable number of reference cycles, the main clock is taken to be stopped. The block keeps one 8-bit control and status register in the reference domain. Software reaches this register through a simple write strobe and a combinational read bus.

When a loss is detected, the block does three things. It sets a sticky loss flag. If detection is enabled, it also forces the failover select to the on-chip oscillator and pulses an interrupt request for one cycle. A live monitor bit shows whether the main clock is stopped at this moment.

All register writes depend on an external write-protect enable. A clock-change lock input additionally freezes the detection-enable bit. The clock multiplexer itself sits outside this block and consumes `osc_sel`.

Top module: `mclk_loss_guard`

## Requirements
- R1: After reset, the register reads 0x00. Bit positions are: detection enable at bit 0, failover select at bit 1, loss flag at bit 2, and monitor at bit 3. Bits 7 to 4 always read 0.
- R2: A write is ignored in every bit while `prot_we` is 0.
- R3: While `chg_lock` is 1, a write leaves the enable bit unchanged. The other writable bits still take the write.
- R4: A loss detected while the enable bit is 1 sets the select bit to 1, which means the on-chip oscillator is selected. `osc_sel` equals the select bit.
- R5: Hardware never clears the select bit, including after the main clock restarts. Only a software write of 0 clears it.
- R6: Hardware sets the loss flag on every detected loss. A software write of 0 clears it, and a software write of 1 has no effect.
- R7: If the flag is cleared while the main clock is still stopped, it stays 0 until the main clock has run again and a new loss is detected.
- R8: The monitor bit is read-only. It reads 1 while the main clock is stopped and 0 while it runs. It rises only after at least TIMEOUT reference cycles with no observed toggle.
- R9: A write of 0 to the select bit is rejected while both the enable bit and the monitor bit are 1.
- R10: `irq` is a one-cycle pulse issued once per new loss event while the enable bit is 1. It stays 0 for a loss that occurs while detection is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running on-chip reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_clk | input | 1 | Monitored main clock |
| wr_en | input | 1 | Register write strobe (reference domain) |
| wr_data | input | 8 | Register write data |
| prot_we | input | 1 | Write-protect enable; 1 permits writes |
| chg_lock | input | 1 | Clock-change lock; 1 freezes the enable bit |
| rd_data | output | 8 | Register read value |
| osc_sel | output | 1 | 1 selects the on-chip oscillator as CPU clock |
| irq | output | 1 | One-cycle loss interrupt request |

## Verification
The bench builds the block with TIMEOUT set to 5 and leaves two synchronizer stages. With these values a loss is declared within about ten reference cycles of stopping the main clock, which makes repeated stop and restart cycles cheap to run. It also keeps an early sample, taken two cycles after the stop, safely inside the no-loss window. The main clock runs at a period 1.5 times the reference period, so the synchronizer sees a toggle nearly every cycle, and the timeout can only expire on a genuine stop.

// File: rtl/mclk_loss_pkg.sv
package mclk_loss_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_EN    = 0;
  localparam int BIT_SEL   = 1;
  localparam int BIT_FLAG  = 2;
  localparam int BIT_MON   = 3;

  // Timeout test: counter has reached the configured limit
  function automatic logic f_expired(input int unsigned cnt, input int unsigned limit);
    return cnt >= limit;
  endfunction

  // Assemble the visible register value; reserved bits are zero
  function automatic logic [REG_W-1:0] f_pack(input logic en, input logic sel,
                                              input logic flag, input logic mon);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_EN]   = en;
    v[BIT_SEL]  = sel;
    v[BIT_FLAG] = flag;
    v[BIT_MON]  = mon;
    return v;
  endfunction
endpackage

// File: rtl/mclk_toggle_sync.sv
module mclk_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic main_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic act
);
  localparam int DEPTH = STAGES + 1;

  logic             tog_q;
  logic [DEPTH-1:0] pipe_q;

  always_ff @(posedge main_clk or negedge rst_n)
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) pipe_q[0] <= 1'b0;
    else        pipe_q[0] <= tog_q;

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge ref_clk or negedge rst_n)
      if (!rst_n) pipe_q[i] <= 1'b0;
      else        pipe_q[i] <= pipe_q[i-1];
  end

  // Edge of the synchronized toggle means the main clock ran
  assign act = pipe_q[DEPTH-1] ^ pipe_q[DEPTH-2];
endmodule

// File: rtl/mclk_stop_timer.sv
module mclk_stop_timer
  import mclk_loss_pkg::*;
#(
  parameter int TIMEOUT = 8
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic act,
  output logic stopped,
  output logic loss_evt
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic [CW-1:0] cnt_q;
  logic          stopped_d_q;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                               cnt_q <= '0;
    else if (act)                             cnt_q <= '0;
    else if (!f_expired(cnt_q, TIMEOUT))      cnt_q <= cnt_q + 1'b1;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) stopped_d_q <= 1'b0;
    else        stopped_d_q <= stopped;

  assign stopped  = f_expired(cnt_q, TIMEOUT);
  assign loss_evt = stopped & ~stopped_d_q;

  // Any observed toggle clears the stopped state on the next cycle
  AST_ACT_CLEARS_STOP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    act |=> !stopped); // R8
  // A new loss event needs the main clock to have been seen running first
  AST_LOSS_NEEDS_RUN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stopped |=> !loss_evt); // R7
endmodule

// File: rtl/mclk_ctrl_reg.sv
module mclk_ctrl_reg
  import mclk_loss_pkg::*;
(
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             prot_we,
  input  logic             chg_lock,
  input  logic             stopped,
  input  logic             loss_evt,
  output logic [REG_W-1:0] rd_data,
  output logic             osc_sel,
  output logic             irq
);
  logic en_q, sel_q, flag_q, irq_q;
  logic wr_ok, en_wr, sel_clr_blocked;

  assign wr_ok           = wr_en & prot_we;
  assign en_wr           = wr_ok & ~chg_lock;
  assign sel_clr_blocked = en_q & stopped;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)     en_q <= 1'b0;
    else if (en_wr) en_q <= wr_data[BIT_EN];

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                      sel_q <= 1'b0;
    else if (loss_evt && en_q)       sel_q <= 1'b1;
    else if (wr_ok) begin
      if (wr_data[BIT_SEL])          sel_q <= 1'b1;
      else if (!sel_clr_blocked)     sel_q <= 1'b0;
    end

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n)                             flag_q <= 1'b0;
    else if (loss_evt)                      flag_q <= 1'b1;
    else if (wr_ok && !wr_data[BIT_FLAG])   flag_q <= 1'b0;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= loss_evt & en_q;

  assign rd_data = f_pack(en_q, sel_q, flag_q, stopped);
  assign osc_sel = sel_q;
  assign irq     = irq_q;

  AST_PROT_HOLDS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !prot_we && !loss_evt |=> $stable(rd_data[2:0])); // R2
  AST_LOCK_HOLDS_EN: assert property (@(posedge ref_clk) disable iff (!rst_n)
    chg_lock |=> en_q == $past(en_q)); // R3
  AST_LOSS_SETS_SEL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    loss_evt && en_q |=> sel_q); // R4
  AST_SEL_NO_HW_CLEAR: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sel_q && !(wr_ok && !wr_data[BIT_SEL]) |=> sel_q); // R5
  AST_FLAG_HW_ONLY_SET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !flag_q && !loss_evt |=> !flag_q); // R6
  AST_SEL_GUARD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    sel_q && en_q && stopped |=> sel_q); // R9
  AST_IRQ_FROM_LOSS: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq |-> $past(loss_evt) && $past(en_q)); // R10
  AST_IRQ_SINGLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    irq |=> !irq); // R10
endmodule

// File: rtl/mclk_loss_guard.sv
module mclk_loss_guard
  import mclk_loss_pkg::*;
#(
  parameter int TIMEOUT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             main_clk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             prot_we,
  input  logic             chg_lock,
  output logic [REG_W-1:0] rd_data,
  output logic             osc_sel,
  output logic             irq
);
  logic act, stopped, loss_evt;

  mclk_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .main_clk(main_clk), .ref_clk(ref_clk), .rst_n(rst_n), .act(act));

  mclk_stop_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .ref_clk(ref_clk), .rst_n(rst_n), .act(act),
    .stopped(stopped), .loss_evt(loss_evt));

  mclk_ctrl_reg u_reg (
    .ref_clk(ref_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .prot_we(prot_we), .chg_lock(chg_lock), .stopped(stopped),
    .loss_evt(loss_evt), .rd_data(rd_data), .osc_sel(osc_sel), .irq(irq));

  AST_RSVD_ZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
    wr_en |=> rd_data[7:4] == 4'h0); // R1
  AST_MON_MATCHES: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(rd_data[BIT_MON]) |-> $past(!act)); // R8
endmodule

// File: tb/mclk_loss_guard_bench.sv
`timescale 1ns/1ps
module mclk_loss_guard_bench;
  localparam int TO = 5;

  logic       ref_clk = 1'b0, main_clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, prot_we = 1'b1, chg_lock = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       osc_sel, irq;
  logic       mrun = 1'b1;
  int         errors = 0, checks = 0, irq_cnt = 0;

  mclk_loss_guard #(.TIMEOUT(TO), .SYNC_STAGES(2)) u_mclk_loss_guard (
    .ref_clk(ref_clk), .rst_n(rst_n), .main_clk(main_clk), .wr_en(wr_en),
    .wr_data(wr_data), .prot_we(prot_we), .chg_lock(chg_lock),
    .rd_data(rd_data), .osc_sel(osc_sel), .irq(irq));

  always #10 ref_clk = ~ref_clk;               // 50 MHz reference
  always begin #15; if (mrun) main_clk = ~main_clk; end

  always @(posedge ref_clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge ref_clk); wr_en = 1'b1; wr_data = d;
    @(negedge ref_clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R1 reset value", rd_data, 8'h00);
    chk("R4 osc_sel reset", osc_sel, 0);
  endtask

  task automatic t_loss_enabled;
    wr(8'h01);
    chk("R3 enable writable unlocked", rd_data, 8'h01);
    mrun = 1'b0; cyc(2);
    chk("R8 no early loss", rd_data[3], 0);
    cyc(20);
    chk("R4 R6 R8 loss sets sel flag mon", rd_data, 8'h0F);
    chk("R4 osc_sel follows", osc_sel, 1);
    chk("R10 one irq", irq_cnt, 1);
  endtask

  task automatic t_guard_and_rearm;
    wr(8'h01);   // clear sel (blocked) and flag while stopped
    chk("R9 sel clear blocked, R6 flag cleared", rd_data, 8'h0B);
    cyc(20);
    chk("R7 flag stays clear while stopped", rd_data[2], 0);
    mrun = 1'b1; cyc(10);
    chk("R5 R8 sel sticky after restart", rd_data, 8'h03);
    wr(8'h01);
    chk("R5 sw clears sel", rd_data, 8'h01);
    mrun = 1'b0; cyc(22);
    chk("R7 rearmed after restart", rd_data, 8'h0F);
    chk("R10 second irq", irq_cnt, 2);
    mrun = 1'b1; cyc(10);
    chk("R6 flag sticky after restart", rd_data, 8'h07);
  endtask

  task automatic t_flag_sw_set;
    wr(8'h01);
    chk("R6 clear", rd_data, 8'h01);
    wr(8'h05);
    chk("R6 sw write 1 ignored", rd_data, 8'h01);
  endtask

  task automatic t_protect;
    prot_we = 1'b0; wr(8'h06);
    chk("R2 protected write ignored", rd_data, 8'h01);
    prot_we = 1'b1;
  endtask

  task automatic t_lock;
    chg_lock = 1'b1; wr(8'h02);
    chk("R3 lock keeps enable, sel written", rd_data, 8'h03);
    chg_lock = 1'b0; wr(8'hF0);
    chk("R1 reserved read zero", rd_data, 8'h00);
  endtask

  task automatic t_disabled_loss;
    mrun = 1'b0; cyc(22);
    chk("R10 R4 disabled loss: flag only", rd_data, 8'h0C);
    chk("R10 no irq when disabled", irq_cnt, 2);
    chk("R4 osc_sel stays 0", osc_sel, 0);
    wr(8'h08);
    chk("R8 monitor read-only", rd_data, 8'h08);
    mrun = 1'b1; cyc(10);
    chk("R8 monitor clears on run", rd_data, 8'h00);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1;
    t_reset();
    t_loss_enabled();
    t_guard_and_rearm();
    t_flag_sw_set();
    t_protect();
    t_lock();
    t_disabled_loss();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule